// File: doc/BRIEF.md
# Split-Word 64-bit Counter Register Bank

This block holds a small bank of 64-bit registers that a 32-bit register bus can reach without tearing values. Each 64-bit register takes two neighbouring word addresses. The even word carries bits 63..32 and the odd word carries bits 31..0. A write to the even word only fills a staging register. The write to the odd word commits the staged upper half and the new lower half together, in one clock edge. On the read side, reading the even word also copies the lower half into a shadow latch. The next odd-word read of the same register returns that copy, so a counter that is still running reads back as one coherent 64-bit value.

Register 0 is a configuration word. Bit 31 of its lower half is a software-reset request that clears itself. Registers 1 to 7 are performance counters. Three of them count request pulses: dequeued requests, outbound encrypt requests and inbound decrypt requests. Four of them add a byte count on each valid beat: outbound bytes encrypted, outbound bytes protected, inbound bytes decrypted and inbound bytes validated. Software can also load any counter through the same split-write path.

Top module: `split64_ctr_bank`

## Requirements
- R1: `bus_addr` is a word address. Register index = `bus_addr[3:1]`. `bus_addr[0]`=0 selects bits 63..32 and `bus_addr[0]`=1 selects bits 31..0. Index 0 is the configuration word, which also drives `cfg_out`. Indices 1..3 are the request counters `req_evt[0..2]` and indices 4..7 are the byte counters on lanes 0..3. Read data appears on `bus_rdata` in the cycle after `bus_rd`.
- R2: A write to an even word changes no register. It only loads the staging register.
- R3: A write to an odd word commits {staging, `bus_wdata`} to the addressed register. The staging register is zero after either reset, so a lone odd-word write then gives an upper half of zero.
- R4: An even-word read captures the lower half of the same register. The next odd-word read of that register returns the captured value, even if the counter has moved since.
- R5: Any odd-word read consumes the captured value. An odd-word read with no capture pending for that register returns the live lower half.
- R6: A request counter adds 1 for each clock cycle in which its `req_evt` bit is high.
- R7: A byte counter adds the unsigned 8-bit lane of `byte_cnt` (lane k = bits 8k+7..8k) in each cycle in which `byte_vld[k]` is high. It ignores the lane when the valid bit is low. All lanes can count in the same cycle.
- R8: Every counter wraps modulo 2^64.
- R9: When a commit to a counter and that counter's event fall in the same cycle, the committed value is stored and the event is lost.
- R10: Committing the configuration word with bit 31 of its lower half set makes `cfg_out[31]` high for exactly one cycle. The bit then clears by itself.
- R11: In the cycle after that commit, all counters, the staging register and the shadow latch clear, and events sampled in that cycle are lost. The other configuration bits are kept, and the bus keeps working.
- R12: After `rst_n` is deasserted, every register reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_rd | input | 1 | Read strobe, one word per cycle |
| bus_addr | input | 4 | Word address: register index and half |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| req_evt | input | 3 | Request event pulses, one per request counter |
| byte_vld | input | 4 | Valid beat per byte lane |
| byte_cnt | input | 32 | Four 8-bit byte counts |
| cfg_out | output | 64 | Committed configuration word |

## Verification
Two pairs of functions can share one cycle. The first pair is a committing odd-word write to a counter and that counter's own event. The second pair is a software-reset clear and an incoming event. The bench drives the write strobe and the event pulse from the same falling edge, so both are sampled on the same rising edge. The result is then read back as a full 64-bit value and compared against the written value, or against zero for the reset case. A third overlap is checked the same way: a pending shadow capture with counting in between, where the carry into the upper half makes a torn read show up.

// File: rtl/split64_pkg.sv
package split64_pkg;

  localparam int DW       = 64;
  localparam int WW       = 32;
  localparam int CNT_MAXW = 16;

  typedef logic [DW-1:0] dword_t;
  typedef logic [WW-1:0] word_t;

  typedef enum logic {
    HALF_HI = 1'b0,
    HALF_LO = 1'b1
  } half_e;

  // increment applied to a counter in one cycle
  function automatic dword_t ctr_amount(input logic is_byte, input logic vld,
                                        input logic [CNT_MAXW-1:0] cnt);
    dword_t a;
    a = '0;
    if (vld) begin
      if (is_byte) a = dword_t'(cnt);
      else         a = dword_t'(1);
    end
    return a;
  endfunction

  function automatic dword_t ctr_step(input dword_t q, input dword_t amt);
    return q + amt;
  endfunction

  function automatic dword_t join_halves(input word_t hi, input word_t lo);
    return {hi, lo};
  endfunction

endpackage

// File: rtl/split64_wr_stage.sv
module split64_wr_stage
  import split64_pkg::*;
#(
  parameter int IDXW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            soft_clr,
  input  logic            wr,
  input  logic            half,
  input  logic [IDXW-1:0] idx,
  input  word_t           wdata,
  output logic            commit,
  output logic [IDXW-1:0] commit_idx,
  output dword_t          commit_val
);

  word_t stage_q;
  logic  wr_hi;
  logic  wr_lo;

  assign wr_hi = wr && (half == HALF_HI);
  assign wr_lo = wr && (half == HALF_LO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stage_q <= '0;
    else if (wr_hi)   stage_q <= wdata;
    else if (soft_clr) stage_q <= '0;
  end

  assign commit     = wr_lo;
  assign commit_idx = idx;
  assign commit_val = join_halves(stage_q, wdata);

  AST_STAGE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> stage_q == $past(wdata)); // R2
  AST_STAGE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_clr && !wr_hi) |=> stage_q == '0); // R11
  AST_STAGE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_hi && !soft_clr) |=> $stable(stage_q)); // R3

endmodule

// File: rtl/split64_rd_shadow.sv
module split64_rd_shadow
  import split64_pkg::*;
#(
  parameter int NREG = 8,
  parameter int IDXW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            soft_clr,
  input  logic            rd,
  input  logic            half,
  input  logic [IDXW-1:0] idx,
  input  dword_t          live [NREG],
  output word_t           rdata
);

  dword_t          sel;
  word_t           shw_q;
  logic            shw_vld_q;
  logic [IDXW-1:0] shw_idx_q;
  logic            rd_hi;
  logic            rd_lo;
  logic            lo_hit;

  assign sel    = live[idx];
  assign rd_hi  = rd && (half == HALF_HI);
  assign rd_lo  = rd && (half == HALF_LO);
  assign lo_hit = rd_lo && shw_vld_q && (shw_idx_q == idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd_hi) begin
      rdata <= sel[DW-1:WW];
    end else if (rd_lo) begin
      rdata <= lo_hit ? shw_q : sel[WW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shw_q     <= '0;
      shw_vld_q <= 1'b0;
      shw_idx_q <= '0;
    end else if (soft_clr) begin
      shw_q     <= '0;
      shw_vld_q <= 1'b0;
      shw_idx_q <= '0;
    end else if (rd_hi) begin
      shw_q     <= sel[WW-1:0];
      shw_vld_q <= 1'b1;
      shw_idx_q <= idx;
    end else if (rd_lo) begin
      shw_vld_q <= 1'b0;
    end
  end

  AST_SHADOW_RETURNED: assert property (@(posedge clk) disable iff (!rst_n)
    lo_hit |=> rdata == $past(shw_q)); // R4
  AST_SHADOW_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lo |=> !shw_vld_q); // R5
  AST_SHADOW_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> !shw_vld_q && shw_q == '0); // R11
  AST_RDATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rdata)); // R1

endmodule

// File: rtl/split64_ctr_cell.sv
module split64_ctr_cell
  import split64_pkg::*;
#(
  parameter int BCW     = 8,
  parameter bit IS_BYTE = 1'b0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           soft_clr,
  input  logic           load,
  input  dword_t         load_val,
  input  logic           evt_vld,
  input  logic [BCW-1:0] evt_cnt,
  output dword_t         q
);

  dword_t amt;

  assign amt = ctr_amount(IS_BYTE, evt_vld, CNT_MAXW'(evt_cnt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q <= '0;
    else if (soft_clr) q <= '0;
    else if (load)     q <= load_val;
    else               q <= ctr_step(q, amt);
  end

  AST_CTR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> q == '0); // R11
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !soft_clr) |=> q == $past(load_val)); // R9
  AST_CTR_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !soft_clr && !evt_vld) |=> $stable(q)); // R7

  if (!IS_BYTE) begin : g_req_chk
    AST_REQ_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !soft_clr && evt_vld) |=> (q - $past(q)) == dword_t'(1)); // R6
  end

endmodule

// File: rtl/split64_ctr_bank.sv
module split64_ctr_bank
  import split64_pkg::*;
#(
  parameter int NREQ  = 3,
  parameter int NBYTE = 4,
  parameter int BCW   = 8,
  parameter int NREG  = 1 + NREQ + NBYTE,
  parameter int IDXW  = $clog2(NREG),
  parameter int AW    = IDXW + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [AW-1:0]        bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [NREQ-1:0]      req_evt,
  input  logic [NBYTE-1:0]     byte_vld,
  input  logic [NBYTE*BCW-1:0] byte_cnt,
  output logic [63:0]          cfg_out
);

  localparam int SRST_BIT = 31;

  logic            half;
  logic [IDXW-1:0] idx;
  logic            commit;
  logic [IDXW-1:0] commit_idx;
  dword_t          commit_val;
  dword_t          cfg_q;
  logic            soft_clr;
  logic            cfg_commit;
  dword_t          live [NREG];

  assign half       = bus_addr[0];
  assign idx        = bus_addr[AW-1:1];
  assign soft_clr   = cfg_q[SRST_BIT];
  assign cfg_commit = commit && (commit_idx == '0);

  split64_wr_stage #(.IDXW(IDXW)) u_stage (
    .clk        (clk),
    .rst_n      (rst_n),
    .soft_clr   (soft_clr),
    .wr         (bus_wr),
    .half       (half),
    .idx        (idx),
    .wdata      (bus_wdata),
    .commit     (commit),
    .commit_idx (commit_idx),
    .commit_val (commit_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cfg_q <= '0;
    else if (cfg_commit) cfg_q <= commit_val;
    else if (soft_clr)   cfg_q[SRST_BIT] <= 1'b0;
  end

  assign cfg_out = cfg_q;
  assign live[0] = cfg_q;

  for (genvar gi = 1; gi < NREG; gi++) begin : g_ctr
    localparam bit IS_B = (gi > NREQ);
    logic           ev_v;
    logic [BCW-1:0] ev_c;
    if (IS_B) begin : g_byte
      assign ev_v = byte_vld[gi-NREQ-1];
      assign ev_c = byte_cnt[(gi-NREQ-1)*BCW +: BCW];
    end else begin : g_req
      assign ev_v = req_evt[gi-1];
      assign ev_c = '0;
    end
    split64_ctr_cell #(.BCW(BCW), .IS_BYTE(IS_B)) u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_clr (soft_clr),
      .load     (commit && (commit_idx == IDXW'(gi))),
      .load_val (commit_val),
      .evt_vld  (ev_v),
      .evt_cnt  (ev_c),
      .q        (live[gi])
    );
  end

  split64_rd_shadow #(.NREG(NREG), .IDXW(IDXW)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .soft_clr (soft_clr),
    .rd       (bus_rd),
    .half     (half),
    .idx      (idx),
    .live     (live),
    .rdata    (bus_rdata)
  );

  AST_SRST_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_clr && !cfg_commit) |=> !cfg_q[SRST_BIT]); // R10
  AST_CFG_KEEPS_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_commit) |=> cfg_q[SRST_BIT-1:0] == $past(cfg_q[SRST_BIT-1:0])
                      && cfg_q[DW-1:WW] == $past(cfg_q[DW-1:WW])); // R11
  AST_HI_WRITE_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && half == HALF_HI && !soft_clr) |=> $stable(cfg_q)); // R2

endmodule

// File: tb/split64_ctr_bank_tb_top.sv
module split64_ctr_bank_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_rd;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [2:0]  req_evt;
  logic [3:0]  byte_vld;
  logic [31:0] byte_cnt;
  logic [63:0] cfg_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [63:0] exp_v [8];

  always #(CLK_PERIOD/2) clk = ~clk;

  split64_ctr_bank dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .req_evt(req_evt), .byte_vld(byte_vld), .byte_cnt(byte_cnt),
    .cfg_out(cfg_out)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr_word(input int r, input bit lo, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = 4'(r*2 + int'(lo)); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_word(input int r, input bit lo, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = 4'(r*2 + int'(lo));
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd64(input int r, output logic [63:0] v);
    logic [31:0] h, l;
    rd_word(r, 1'b0, h);
    rd_word(r, 1'b1, l);
    v = {h, l};
  endtask

  task automatic wr64(input int r, input logic [63:0] v);
    wr_word(r, 1'b0, v[63:32]);
    wr_word(r, 1'b1, v[31:0]);
    exp_v[r] = v;
  endtask

  task automatic pulse(input logic [2:0] rq, input logic [3:0] bv, input logic [31:0] bc);
    req_evt = rq; byte_vld = bv; byte_cnt = bc;
    @(negedge clk);
    req_evt = '0; byte_vld = '0; byte_cnt = '0;
    for (int k = 0; k < 3; k++) if (rq[k]) exp_v[1+k] = exp_v[1+k] + 64'd1;
    for (int k = 0; k < 4; k++) if (bv[k]) exp_v[4+k] = exp_v[4+k] + 64'(bc[k*8 +: 8]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    logic [31:0] w;
    bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0;
    req_evt = '0; byte_vld = '0; byte_cnt = '0;
    for (int i = 0; i < 8; i++) exp_v[i] = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12: every register zero after reset
    for (int i = 0; i < 8; i++) begin
      rd64(i, v);
      chk($sformatf("R12 reg%0d reset", i), v, 64'd0);
    end

    // R1: word mapping of the configuration register
    wr64(0, 64'h1111_2222_3333_4444);
    chk("R1 cfg_out mapping", cfg_out, 64'h1111_2222_3333_4444);
    rd_word(0, 1'b0, w); chk("R1 cfg high word", 64'(w), 64'h1111_2222);
    rd_word(0, 1'b1, w); chk("R1 cfg low word", 64'(w), 64'h3333_4444);

    // R6: request counters, i+2 pulses each, plus one joint pulse
    for (int i = 0; i < 3; i++)
      for (int k = 0; k < i + 2; k++) pulse(3'(1 << i), 4'h0, 32'h0);
    pulse(3'b111, 4'h0, 32'h0);
    for (int i = 1; i <= 3; i++) begin
      rd64(i, v);
      chk($sformatf("R6 req counter %0d", i), v, exp_v[i]);
    end

    // R7: byte lanes, valid/invalid beats and all lanes together
    for (int b = 0; b < 4; b++) begin
      pulse(3'b0, 4'(1 << b), 32'hFF << (b*8));
      pulse(3'b0, 4'(1 << b), 32'(b*17 + 3) << (b*8));
      pulse(3'b0, 4'h0, 32'h5555_5555);
    end
    pulse(3'b0, 4'hF, 32'h04_03_02_01);
    pulse(3'b0, 4'h5, 32'hFF_FF_FF_FF);
    for (int i = 4; i <= 7; i++) begin
      rd64(i, v);
      chk($sformatf("R7 byte counter %0d", i), v, exp_v[i]);
    end

    // R2 then R3: staged upper half does not show until the low write
    wr_word(1, 1'b0, 32'h0BAD_F00D);
    rd64(1, v);
    chk("R2 high write only stages", v, exp_v[1]);
    wr_word(1, 1'b1, 32'h1357_9BDF);
    exp_v[1] = 64'h0BAD_F00D_1357_9BDF;
    rd64(1, v);
    chk("R3 low write commits", v, exp_v[1]);

    // R8: wrap on request and byte counters
    wr64(2, 64'hFFFF_FFFF_FFFF_FFFF);
    pulse(3'b010, 4'h0, 32'h0);
    rd64(2, v); chk("R8 request wrap", v, 64'd0);
    wr64(5, 64'hFFFF_FFFF_FFFF_FFF0);
    pulse(3'b0, 4'b0010, 32'h0000_2000);
    rd64(5, v); chk("R8 byte wrap", v, 64'h10);

    // R4 / R5: shadow capture across a carry into the upper half
    wr64(4, 64'h0000_0001_FFFF_FFF0);
    rd_word(4, 1'b0, w); chk("R4 high half", 64'(w), 64'h1);
    pulse(3'b0, 4'b0001, 32'h20);
    rd_word(4, 1'b1, w); chk("R4 captured low half", 64'(w), 64'hFFFF_FFF0);
    rd_word(4, 1'b1, w); chk("R5 capture consumed, live", 64'(w), 64'h10);
    rd_word(4, 1'b0, w); chk("R4 high after carry", 64'(w), 64'h2);
    pulse(3'b0, 4'b0010, 32'h0000_0700);
    rd_word(5, 1'b1, w); chk("R5 other register reads live", 64'(w), exp_v[5][31:0]);

    // R9: commit and event in the same cycle
    wr_word(1, 1'b0, 32'hDEAD_0000);
    bus_wr = 1'b1; bus_addr = 4'd3; bus_wdata = 32'h0000_BEEF; req_evt = 3'b001;
    @(negedge clk);
    bus_wr = 1'b0; req_evt = '0;
    exp_v[1] = 64'hDEAD_0000_0000_BEEF;
    rd64(1, v); chk("R9 write wins over event", v, exp_v[1]);

    // R10 / R11: software reset
    rd_word(3, 1'b0, w);               // leave a capture pending on reg 3
    wr_word(0, 1'b0, 32'hA5A5_0000);
    wr_word(0, 1'b1, 32'h8000_00FF);
    chk("R10 reset bit set", 64'(cfg_out[31]), 64'd1);
    req_evt = 3'b010; byte_vld = 4'hF; byte_cnt = 32'h1111_1111;
    @(negedge clk);
    req_evt = '0; byte_vld = '0; byte_cnt = '0;
    chk("R10 reset bit self-cleared", 64'(cfg_out[31]), 64'd0);
    for (int i = 1; i < 8; i++) exp_v[i] = '0;
    rd_word(3, 1'b1, w); chk("R11 shadow cleared, live low", 64'(w), 64'd0);
    for (int i = 1; i < 8; i++) begin
      rd64(i, v);
      chk($sformatf("R11 counter %0d cleared", i), v, 64'd0);
    end
    rd64(0, v); chk("R11 config kept", v, 64'hA5A5_0000_0000_00FF);
    wr_word(2, 1'b1, 32'h7);
    rd64(2, v); chk("R3 staging cleared, lone low write", v, 64'h7);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule